// File: doc/BRIEF.md
# Zero-Cross Detector Edge Interrupt Controller

This block is the digital control and interrupt logic that sits around an external zero-crossing comparator. The comparator level arrives asynchronously. It passes through a two-flop synchronizer, and a programmable polarity is then applied to it. The result can be read as a status bit. Enabled rising and/or falling transitions of that polarity-adjusted level set a sticky interrupt flag. Software clears the flag with a strobe.

Software reaches the block through one 8-bit control register with a write strobe and a continuous read-back. The enable bit asserts a pad-override output so that the detector owns the pin. A configuration input chooses whether the enable bit comes out of reset set or cleared. The interrupt request is the flag gated by an external peripheral interrupt-enable input.

Top module: `zcd_irq_ctrl`

## Requirements
- R1: Control register fields: bit 7 detector enable, bit 4 polarity, bit 1 rising-edge interrupt enable, bit 0 falling-edge interrupt enable. All four are written by `reg_we` and read back on `reg_rdata`. Bits 6, 3 and 2 always read 0. Bit 5 is read-only, and writes to it have no effect.
- R2: `reg_rdata[5]` shows the comparator level after a two-flop synchronizer, inverted when polarity is 1. It changes two clock edges after the input changes.
- R3: With the rising-edge enable at 1 and the detector enabled, a 0-to-1 change of the adjusted level sets the flag on the next clock edge.
- R4: With the falling-edge enable at 1 and the detector enabled, a 1-to-0 change of the adjusted level sets the flag on the next clock edge.
- R5: A transition whose direction enable is 0 leaves the flag unchanged.
- R6: `pad_ovr` equals the detector enable bit.
- R7: Reset clears polarity, both edge enables and the flag. The enable bit resets to 1 when `cfg_det_off` is 0, and to 0 otherwise.
- R8: The flag stays set until `flag_clr` is pulsed. When a set event and `flag_clr` fall in the same cycle, the flag stays set.
- R9: While the enable bit is 0 the flag is never set. Turning enable on does not, by itself, produce an edge, even when the adjusted level is 1.
- R10: Changing polarity while enabled counts as a transition of the adjusted level and sets the flag according to the edge enables.
- R11: `irq` equals the flag ANDed with `irq_en`.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_det_off | input | 1 | Configuration: 1 makes the enable bit reset to 0 |
| cmp_async | input | 1 | Asynchronous comparator level |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read-back including the adjusted level |
| flag_clr | input | 1 | Flag clear strobe |
| irq_en | input | 1 | Peripheral interrupt enable |
| pad_ovr | output | 1 | Pad override, the pin is driven by the detector |
| flag | output | 1 | Sticky interrupt flag |
| irq | output | 1 | Interrupt request |

## Verification
A wrong synchronizer depth or a misplaced polarity inversion shows up on `reg_rdata[5]` one cycle early or late, or with the wrong sense, within two edges of a comparator change. A stale edge-history register or a missing enable gate shows up as a flag that rises when it should not, or stays low when it should rise. The flag is sticky, so such an error stays visible on `flag` and `irq` until the next clear. The reference model is compared against all four outputs on every cycle, so any divergence is caught in the cycle it first appears.

// File: rtl/zcd_pkg.sv
package zcd_pkg;
    localparam int REG_W      = 8;
    localparam int SYNC_DEPTH = 2;

    localparam int BIT_EN   = 7;
    localparam int BIT_OUT  = 5;
    localparam int BIT_POL  = 4;
    localparam int BIT_RISE = 1;
    localparam int BIT_FALL = 0;

    typedef struct packed {
        logic en;
        logic pol;
        logic rise_en;
        logic fall_en;
    } zcd_ctrl_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } zcd_edge_t;

    function automatic zcd_ctrl_t unpack_ctrl(input logic [REG_W-1:0] w);
        zcd_ctrl_t c;
        c.en      = w[BIT_EN];
        c.pol     = w[BIT_POL];
        c.rise_en = w[BIT_RISE];
        c.fall_en = w[BIT_FALL];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_status(input zcd_ctrl_t c, input logic lvl);
        logic [REG_W-1:0] r;
        r           = '0;
        r[BIT_EN]   = c.en;
        r[BIT_OUT]  = lvl;
        r[BIT_POL]  = c.pol;
        r[BIT_RISE] = c.rise_en;
        r[BIT_FALL] = c.fall_en;
        return r;
    endfunction
endpackage

// File: rtl/zcd_sync.sv
module zcd_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q
);
    logic [DEPTH-1:0] stages;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stages[i] <= 1'b0;
                    else     stages[i] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stages[i] <= 1'b0;
                    else     stages[i] <= stages[i-1];
                end
            end
        end
    endgenerate

    assign q = stages[DEPTH-1];
endmodule

// File: rtl/zcd_ctrl_reg.sv
module zcd_ctrl_reg
    import zcd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_det_off,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output zcd_ctrl_t        ctrl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.en      <= ~cfg_det_off;
            ctrl.pol     <= 1'b0;
            ctrl.rise_en <= 1'b0;
            ctrl.fall_en <= 1'b0;
        end else if (we) begin
            ctrl <= unpack_ctrl(wdata);
        end
    end
endmodule

// File: rtl/zcd_edge_flag.sv
module zcd_edge_flag
    import zcd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  zcd_ctrl_t ctrl,
    input  logic      lvl,
    input  logic      clr,
    output logic      flag
);
    logic      hist;
    logic      en_q;
    logic      armed;
    zcd_edge_t edges;
    logic      set_evt;

    // Detection runs only once enable has been high for a full cycle, so the
    // history register reloads on the enabling cycle without raising an edge.
    assign armed      = ctrl.en & en_q;
    assign edges.rise = lvl & ~hist;
    assign edges.fall = ~lvl & hist;
    assign set_evt    = armed & ((edges.rise & ctrl.rise_en) | (edges.fall & ctrl.fall_en));

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= 1'b0;
            en_q <= 1'b0;
            flag <= 1'b0;
        end else begin
            hist <= lvl;
            en_q <= ctrl.en;
            if (set_evt)  flag <= 1'b1;
            else if (clr) flag <= 1'b0;
        end
    end
endmodule

// File: rtl/zcd_irq_ctrl.sv
module zcd_irq_ctrl
    import zcd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_det_off,
    input  logic             cmp_async,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             flag_clr,
    input  logic             irq_en,
    output logic             pad_ovr,
    output logic             flag,
    output logic             irq
);
    zcd_ctrl_t ctrl;
    logic      cmp_sync;
    logic      lvl;

    zcd_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (cmp_async),
        .q       (cmp_sync)
    );

    zcd_ctrl_reg u_reg (
        .clk         (clk),
        .rst         (rst),
        .cfg_det_off (cfg_det_off),
        .we          (reg_we),
        .wdata       (reg_wdata),
        .ctrl        (ctrl)
    );

    assign lvl = cmp_sync ^ ctrl.pol;

    zcd_edge_flag u_edge (
        .clk  (clk),
        .rst  (rst),
        .ctrl (ctrl),
        .lvl  (lvl),
        .clr  (flag_clr),
        .flag (flag)
    );

    assign reg_rdata = pack_status(ctrl, lvl);
    assign pad_ovr   = ctrl.en;
    assign irq       = flag & irq_en;
endmodule

// File: rtl/zcd_irq_ctrl_chk.sv
module zcd_irq_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_det_off,
    input logic       reg_we,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       flag_clr,
    input logic       irq_en,
    input logic       pad_ovr,
    input logic       flag,
    input logic       irq
);
    p_unused_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[6] == 1'b0) && (reg_rdata[3:2] == 2'b00));

    p_write_lands_r1: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> (reg_rdata[4] == $past(reg_wdata[4])) && (reg_rdata[1:0] == $past(reg_wdata[1:0])));

    p_pad_tracks_en_r6: assert property (@(posedge clk) disable iff (rst)
        pad_ovr == reg_rdata[7]);

    p_reset_en_r7: assert property (@(posedge clk)
        rst |=> (pad_ovr == !$past(cfg_det_off)) && !flag);

    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (flag && !flag_clr) |=> flag);

    p_quiet_off_r9: assert property (@(posedge clk) disable iff (rst)
        (!pad_ovr && !flag) |=> !flag);

    p_irq_needs_en_r11: assert property (@(posedge clk) disable iff (rst)
        irq |-> (irq_en && flag));
endmodule

bind zcd_irq_ctrl zcd_irq_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_det_off (cfg_det_off),
    .reg_we      (reg_we),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .flag_clr    (flag_clr),
    .irq_en      (irq_en),
    .pad_ovr     (pad_ovr),
    .flag        (flag),
    .irq         (irq)
);

// File: tb/zcd_irq_ctrl_bench.sv
module zcd_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_det_off = 1'b1;
    logic       cmp_async = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       flag_clr = 1'b0;
    logic       irq_en = 1'b0;
    logic       pad_ovr, flag, irq;

    int    n_chk = 0, n_fail = 0, cyc = 0;
    string tag = "R7";
    bit    started = 0;

    // behavioural reference state
    bit m_en, m_pol, m_rise, m_fall, m_hist, m_enq, m_flag;
    bit sq[$];

    always #2 clk = ~clk;

    zcd_irq_ctrl u_zcd_irq_ctrl (
        .clk(clk), .rst(rst), .cfg_det_off(cfg_det_off), .cmp_async(cmp_async),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .flag_clr(flag_clr), .irq_en(irq_en), .pad_ovr(pad_ovr),
        .flag(flag), .irq(irq)
    );

    always @(posedge clk) begin
        cyc++;
        started = 1;
        if (rst) begin
            m_en = !cfg_det_off; m_pol = 0; m_rise = 0; m_fall = 0;
            m_hist = 0; m_enq = 0; m_flag = 0;
            sq = '{0, 0};
        end else begin
            bit lvl, hit;
            lvl = sq[0] ^ m_pol;
            hit = m_en && m_enq && ((m_rise && lvl && !m_hist) || (m_fall && !lvl && m_hist));
            if (hit) m_flag = 1;
            else if (flag_clr) m_flag = 0;
            m_hist = lvl;
            m_enq  = m_en;
            void'(sq.pop_front());
            sq.push_back(cmp_async);
            if (reg_we) begin
                m_en = reg_wdata[7]; m_pol = reg_wdata[4];
                m_rise = reg_wdata[1]; m_fall = reg_wdata[0];
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            logic [7:0] exp_rd;
            exp_rd = {m_en, 1'b0, sq[0] ^ m_pol, m_pol, 2'b00, m_rise, m_fall};
            chk(tag, "reg_rdata", reg_rdata, exp_rd);
            chk("R6", "pad_ovr", {7'b0, pad_ovr}, {7'b0, m_en});
            chk(tag, "flag", {7'b0, flag}, {7'b0, m_flag});
            chk("R11", "irq", {7'b0, irq}, {7'b0, m_flag & irq_en});
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        reg_we = 1; reg_wdata = d;
        tick(1);
        reg_we = 0;
    endtask

    task automatic pulse_clr();
        flag_clr = 1; tick(1); flag_clr = 0;
    endtask

    initial begin
        // R7: reset with the configuration disabling the detector
        tick(3);
        chk("R7", "reset rdata cfg=1", reg_rdata, 8'h00);
        rst = 1; cfg_det_off = 0; tick(2); rst = 0;
        chk("R7", "reset rdata cfg=0", reg_rdata, 8'h80);
        chk("R6", "pad after reset", {7'b0, pad_ovr}, 8'h01);

        // R1: field write and read-only / unimplemented bits
        tag = "R1"; wr(8'hFF); tick(1);
        chk("R1", "all-ones write", reg_rdata & 8'hDF, 8'h93);
        wr(8'h00); tick(1);
        chk("R1", "zero write", reg_rdata, 8'h00);

        // R2: synchronizer delay and polarity
        tag = "R2"; irq_en = 1;
        cmp_async = 1; tick(1);
        chk("R2", "out after 1 edge", {7'b0, reg_rdata[5]}, 8'h00);
        tick(1);
        chk("R2", "out after 2 edges", {7'b0, reg_rdata[5]}, 8'h01);
        wr(8'h10); tick(1);
        chk("R2", "inverted out", {7'b0, reg_rdata[5]}, 8'h00);
        wr(8'h00); cmp_async = 0; tick(4);

        // R3: rising edge enabled
        tag = "R3"; wr(8'h82); tick(3);
        cmp_async = 1; tick(3);
        chk("R3", "flag after rise", {7'b0, flag}, 8'h01);
        chk("R11", "irq with enable", {7'b0, irq}, 8'h01);
        irq_en = 0; tick(1);
        chk("R11", "irq gated", {7'b0, irq}, 8'h00);
        irq_en = 1;

        // R8: sticky, clear, set beats clear
        tag = "R8"; tick(5);
        chk("R8", "still set", {7'b0, flag}, 8'h01);
        pulse_clr(); tick(1);
        chk("R8", "cleared", {7'b0, flag}, 8'h00);
        cmp_async = 0; tick(4);
        cmp_async = 1; tick(2);
        flag_clr = 1; tick(1); flag_clr = 0;
        chk("R8", "set wins over clear", {7'b0, flag}, 8'h01);
        pulse_clr();

        // R5: falling edge with only rise enabled
        tag = "R5"; cmp_async = 0; tick(5);
        chk("R5", "fall ignored", {7'b0, flag}, 8'h00);

        // R4: falling edge enabled
        tag = "R4"; wr(8'h81); cmp_async = 1; tick(5);
        chk("R5", "rise ignored", {7'b0, flag}, 8'h00);
        cmp_async = 0; tick(3);
        chk("R4", "flag after fall", {7'b0, flag}, 8'h01);
        pulse_clr();

        // R10: polarity toggle while enabled
        tag = "R10"; wr(8'h82); tick(3);
        wr(8'h92); tick(1);
        chk("R10", "pol toggle rises", {7'b0, flag}, 8'h01);
        pulse_clr();
        wr(8'h82); tick(2);
        chk("R10", "pol back is a fall", {7'b0, flag}, 8'h00);

        // R9: disabled edges and enabling with a high level
        tag = "R9"; wr(8'h03); cmp_async = 1; tick(4);
        cmp_async = 0; tick(4);
        chk("R9", "no set while off", {7'b0, flag}, 8'h00);
        wr(8'h13); tick(4);
        wr(8'h93); tick(4);
        chk("R9", "enable no false edge", {7'b0, flag}, 8'h00);
        wr(8'h83); tick(4);
        chk("R9", "real edge after enable", {7'b0, flag}, 8'h01);

        // R7: reset clears flag and fields
        tag = "R7"; rst = 1; cfg_det_off = 1; tick(2); rst = 0; tick(1);
        chk("R7", "reset clears", {reg_rdata[7:6], reg_rdata[4:0], flag}, 8'h00);
        tick(2);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule